// File: doc/BRIEF.md
# Prioritised Multi-Processor Interrupt Aggregator

This block gathers 64 interrupt vectors into one pending register and delivers them to up to four processors. A vector becomes pending when a hardware source pulses its input, or when software writes a one to that vector's bit in the set register. A pending vector stays pending until software writes a one to its bit in the clear register. The pending register itself can only be read.

Each processor has its own 64-bit enable mask. For each processor, the masked pending vector is split into five priority levels along fixed, unequal bit ranges. Each level drives one interrupt line: level 0 holds the generic and flow-control sources, and level 4 holds the error sources. The timer sits alone in level 3. A global enable input silences every line but does not stop capture.

Register access uses a simple 64-bit port with separate read and write strobes. Read data is returned one cycle after the read strobe.

Top module: `prio_irq_aggregator`

## Requirements
- R1: After reset, every mask and the pending register read as zero, and every interrupt line is low.
- R2: A write to byte address 0x10000 + 8*c (c = 0..3) loads processor c's mask. A read of the same address returns it one cycle after the read strobe. A mask holds its value when it is not written.
- R3: A write to 0x10020 sets each pending bit whose write-data bit is one. Bits written as zero keep their value.
- R4: A write to 0x10028 clears each pending bit whose write-data bit is one. Bits written as zero keep their value.
- R5: A one-cycle high pulse on bit b of `hw_src` makes pending bit b one in the following cycle.
- R6: When a source pulse and a clear-register write hit the same bit in the same cycle, the bit ends up pending.
- R7: Levels group pending bits as follows: level 0 = bits 15..0, level 1 = bits 31..16, level 2 = bits 49..32, level 3 = bit 50, level 4 = bits 63..51. The line for processor c, level l, is `irq_lvl[5*c + l]`.
- R8: A line is high exactly when, in the previous cycle, at least one bit of its level was both pending and enabled in that processor's mask, with `int_enable` high.
- R9: While `int_enable` is low, all lines go low on the next cycle. Sources and set writes still update the pending register.
- R10: Reads of 0x10020 and 0x10028 return zero. A write to the pending register at 0x10030 changes nothing. `reg_rdata` is zero in any cycle that does not follow a read strobe.
- R11: Accesses to any other address read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| int_enable | input | 1 | Global line enable |
| hw_src | input | 64 | One-cycle hardware source pulses, one per vector |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 20 | Byte address of the access |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid the cycle after `reg_rd` |
| irq_lvl | output | 20 | Interrupt lines, five per processor |

## Verification
A hardware pulse and a software clear can land on the same vector in the same cycle. The bench provokes this by driving a `hw_src` bit in the same cycle as a clear-register write that covers that bit and some other pending bits. It then expects the collided bit to remain pending while the other covered bits drop. It also judges the visible effect on the lines of every processor one cycle later. Long random runs mix pulses, set and clear writes, mask writes, reads and enable toggles against a behavioural model checked every cycle, so such collisions also arise unplanned.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int VEC_W   = 64;
  localparam int NUM_LVL = 5;

  typedef logic [VEC_W-1:0] vec_t;

  // Byte addresses of the register slots
  localparam int MASK_BASE   = 32'h10000;
  localparam int MASK_STRIDE = 8;
  localparam int SET_ADDR    = 32'h10020;
  localparam int CLR_ADDR    = 32'h10028;
  localparam int STAT_ADDR   = 32'h10030;

  // Lowest and highest vector of each priority level
  function automatic int lvl_lo(int l);
    case (l)
      0: return 0;
      1: return 16;
      2: return 32;
      3: return 50;
      default: return 51;
    endcase
  endfunction

  function automatic int lvl_hi(int l);
    case (l)
      0: return 15;
      1: return 31;
      2: return 49;
      3: return 50;
      default: return 63;
    endcase
  endfunction

  function automatic vec_t lvl_mask(int l);
    vec_t m;
    m = '0;
    for (int b = 0; b < VEC_W; b++) begin
      if (b >= lvl_lo(l) && b <= lvl_hi(l)) m[b] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_agg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  vec_t set_vec,
  input  vec_t clr_vec,
  input  vec_t hw_src,
  output vec_t status_q
);

  vec_t status_d;
  logic upd_en;

  // Set (software or hardware) takes precedence over clear
  always_comb begin
    upd_en   = |(set_vec | clr_vec | hw_src);
    status_d = (status_q & ~clr_vec) | set_vec | hw_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (upd_en) begin
      status_q <= status_d;
    end
  end

  // R6: a set of either kind always lands, even against a clear
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_vec | hw_src)) |=> ((status_q & $past(set_vec | hw_src)) == $past(set_vec | hw_src)));

  // R4: cleared bits without a competing set are gone next cycle
  a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec) |=> ((status_q & $past(clr_vec & ~(set_vec | hw_src))) == '0));

  // R10: with no set, clear or source, pending state does not move
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec | clr_vec | hw_src) == '0) |=> $stable(status_q));

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import irq_agg_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CPU-1:0] we,
  input  vec_t               wdata,
  output vec_t [NUM_CPU-1:0] mask_q
);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    vec_t mask_d;

    always_comb begin
      mask_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[c] <= '0;
      end else if (we[c]) begin
        mask_q[c] <= mask_d;
      end
    end

    // R2: a mask only changes when its own slot is written
    a_r2_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !we[c] |=> $stable(mask_q[c]));
  end

endmodule

// File: rtl/irq_level_reduce.sv
module irq_level_reduce
  import irq_agg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  vec_t               status,
  input  vec_t               mask,
  output logic [NUM_LVL-1:0] lvl_q
);

  vec_t               live;
  logic [NUM_LVL-1:0] any_hit;
  logic [NUM_LVL-1:0] lvl_d;

  always_comb begin
    live = status & mask;
  end

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    localparam vec_t LVL_BITS = lvl_mask(l);
    always_comb begin
      any_hit[l] = |(live & LVL_BITS);
    end
  end

  always_comb begin
    lvl_d = enable ? any_hit : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else begin
      lvl_q <= lvl_d;
    end
  end

  // R9: dropping the global enable silences every line next cycle
  a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (lvl_q == '0));

  // R8: nothing pending and enabled means no line next cycle
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & mask) == '0) |=> (lvl_q == '0));

endmodule

// File: rtl/prio_irq_aggregator.sv
module prio_irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       int_enable,
  input  logic [63:0]                hw_src,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [63:0]                reg_wdata,
  output logic [63:0]                reg_rdata,
  output logic [NUM_CPU*NUM_LVL-1:0] irq_lvl
);

  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(SET_ADDR);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(CLR_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

  // Reset: asserted asynchronously, released after two clock edges
  logic rst_meta;
  logic rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_i  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_i  <= rst_meta;
    end
  end

  // Write decode
  vec_t               set_vec;
  vec_t               clr_vec;
  logic [NUM_CPU-1:0] mask_we;

  always_comb begin
    set_vec = (reg_wr && reg_addr == A_SET) ? reg_wdata : '0;
    clr_vec = (reg_wr && reg_addr == A_CLR) ? reg_wdata : '0;
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_we
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_BASE + MASK_STRIDE * c);
    always_comb begin
      mask_we[c] = reg_wr && (reg_addr == A_MASK);
    end
  end

  vec_t               status_q;
  vec_t [NUM_CPU-1:0] mask_q;

  irq_status_reg u_status (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .hw_src   (hw_src),
    .status_q (status_q)
  );

  irq_mask_bank #(.NUM_CPU(NUM_CPU)) u_masks (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .we     (mask_we),
    .wdata  (reg_wdata),
    .mask_q (mask_q)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    irq_level_reduce u_reduce (
      .clk    (clk),
      .rst_n  (rst_n_i),
      .enable (int_enable),
      .status (status_q),
      .mask   (mask_q[c]),
      .lvl_q  (irq_lvl[c*NUM_LVL +: NUM_LVL])
    );
  end

  // Read path: set and clear slots read as zero
  vec_t rd_val;
  vec_t rdata_d;

  always_comb begin
    rd_val = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (reg_addr == ADDR_W'(MASK_BASE + MASK_STRIDE * c)) rd_val = mask_q[c];
    end
    if (reg_addr == A_STAT) rd_val = status_q;
    rdata_d = reg_rd ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= rdata_d;
    end
  end

  // R10: the set and clear slots never return data
  a_r10_setclr_zero: assert property (@(posedge clk) disable iff (!rst_n_i)
    (reg_rd && (reg_addr == A_SET || reg_addr == A_CLR)) |=> (reg_rdata == '0));

  // R10: no read strobe, no read data
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n_i)
    !reg_rd |=> (reg_rdata == '0));

endmodule

// File: tb/prio_irq_aggregator_tb_top.sv
`timescale 1ns/1ps
module prio_irq_aggregator_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        int_enable = 1'b0;
  logic [63:0] hw_src = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [19:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [19:0] irq_lvl;

  always #4 clk = ~clk;

  prio_irq_aggregator dut_i (
    .clk(clk), .rst_n(rst_n), .int_enable(int_enable), .hw_src(hw_src),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_lvl(irq_lvl)
  );

  int total = 0;
  int bad = 0;
  bit cmp_on = 0;
  bit reported = 0;

  function automatic int lvl_of(int b);
    if (b <= 15) return 0;
    if (b <= 31) return 1;
    if (b <= 49) return 2;
    if (b == 50) return 3;
    return 4;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [63:0] m_status;
  logic [63:0] m_mask [4];
  logic [19:0] m_lvl;
  logic [63:0] m_rdata;
  logic [19:0] lv_tmp;
  logic [63:0] rd_tmp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_status <= '0;
      for (int c = 0; c < 4; c++) m_mask[c] <= '0;
      m_lvl   <= '0;
      m_rdata <= '0;
    end else begin
      lv_tmp = '0;
      for (int c = 0; c < 4; c++)
        for (int b = 0; b < 64; b++)
          if (int_enable && m_status[b] && m_mask[c][b]) lv_tmp[c*5 + lvl_of(b)] = 1'b1;
      m_lvl <= lv_tmp;
      rd_tmp = '0;
      if (reg_rd) begin
        for (int c = 0; c < 4; c++) if (reg_addr == 20'h10000 + 20'(8*c)) rd_tmp = m_mask[c];
        if (reg_addr == 20'h10030) rd_tmp = m_status;
      end
      m_rdata <= rd_tmp;
      for (int b = 0; b < 64; b++) begin
        if (hw_src[b] || (reg_wr && reg_addr == 20'h10020 && reg_wdata[b])) m_status[b] <= 1'b1;
        else if (reg_wr && reg_addr == 20'h10028 && reg_wdata[b]) m_status[b] <= 1'b0;
      end
      for (int c = 0; c < 4; c++)
        if (reg_wr && reg_addr == 20'h10000 + 20'(8*c)) m_mask[c] <= reg_wdata;
    end
  end

  // Compare with the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R8 lines vs model", {44'h0, irq_lvl}, {44'h0, m_lvl});
      chk("R2 rdata vs model", reg_rdata, m_rdata);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [19:0] a, logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_chk(string tag, logic [19:0] a, logic [63:0] exp);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic pulse(logic [63:0] v);
    @(negedge clk);
    hw_src = v;
    @(negedge clk);
    hw_src = '0;
  endtask

  // Masks used in the directed part
  logic [63:0] bm [4];

  function automatic logic [19:0] exp_lines(logic [63:0] st);
    logic [19:0] r;
    r = '0;
    for (int c = 0; c < 4; c++)
      for (int b = 0; b < 64; b++)
        if (st[b] && bm[c][b]) r[c*5 + lvl_of(b)] = 1'b1;
    return r;
  endfunction

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    bm[0] = 64'hFFFF_FFFF_FFFF_FFFF;
    bm[1] = 64'h0000_0000_FFFF_0000;
    bm[2] = 64'h0004_0000_0000_0000;
    bm[3] = 64'hFFF8_0000_0000_0000;

    idle(3);
    rst_n = 1'b1;
    idle(4);
    cmp_on = 1;

    // R1 reset state
    chk("R1 lines after reset", {44'h0, irq_lvl}, 64'h0);
    for (int c = 0; c < 4; c++) rd_chk("R1 mask reset", 20'h10000 + 20'(8*c), 64'h0);
    rd_chk("R1 status reset", 20'h10030, 64'h0);

    int_enable = 1'b1;
    // R2 masks
    for (int c = 0; c < 4; c++) wr(20'h10000 + 20'(8*c), bm[c]);
    for (int c = 0; c < 4; c++) rd_chk("R2 mask readback", 20'h10000 + 20'(8*c), bm[c]);

    // R3 set register
    wr(20'h10020, 64'h0000_0100_0010_0001);
    idle(1);
    chk("R3 lines after set", {44'h0, irq_lvl}, {44'h0, exp_lines(64'h0000_0100_0010_0001)});
    rd_chk("R3 status after set", 20'h10030, 64'h0000_0100_0010_0001);

    // R5 hardware pulse on the timer vector
    pulse(64'h0004_0000_0000_0000);
    idle(1);
    chk("R5 timer line cpu2", {63'h0, irq_lvl[13]}, 64'h1);
    rd_chk("R5 status after pulse", 20'h10030, 64'h0004_0100_0010_0001);

    // R4 clear register
    wr(20'h10028, 64'h0000_0000_0010_0000);
    rd_chk("R4 status after clear", 20'h10030, 64'h0004_0100_0000_0001);

    // R6 pulse and clear on the same bit in the same cycle
    @(negedge clk);
    hw_src = 64'h1; reg_wr = 1'b1; reg_addr = 20'h10028; reg_wdata = 64'h0000_0100_0000_0001;
    @(negedge clk);
    hw_src = '0; reg_wr = 1'b0; reg_wdata = '0;
    chk("R6 lines before update", {44'h0, irq_lvl}, {44'h0, exp_lines(64'h0004_0100_0000_0001)});
    @(negedge clk);
    chk("R6 lines after collision", {44'h0, irq_lvl}, {44'h0, exp_lines(64'h0004_0000_0000_0001)});
    rd_chk("R6 collided bit kept", 20'h10030, 64'h0004_0000_0000_0001);

    // R7 level boundaries, one vector at a time
    wr(20'h10028, 64'hFFFF_FFFF_FFFF_FFFF);
    foreach (bm[i]) begin end
    begin
      int edge_bits [9] = '{0, 15, 16, 31, 32, 49, 50, 51, 63};
      foreach (edge_bits[k]) begin
        wr(20'h10020, 64'h1 << edge_bits[k]);
        idle(1);
        chk("R7 level of boundary vector", {44'h0, irq_lvl},
            {44'h0, exp_lines(64'h1 << edge_bits[k])});
        wr(20'h10028, 64'hFFFF_FFFF_FFFF_FFFF);
      end
    end

    // R9 global enable
    wr(20'h10020, 64'h8000_0000_0000_0000);
    idle(1);
    chk("R9 error line with enable", {63'h0, irq_lvl[19]}, 64'h1);
    @(negedge clk);
    int_enable = 1'b0;
    idle(1);
    chk("R9 lines off when disabled", {44'h0, irq_lvl}, 64'h0);
    pulse(64'h0000_0000_0000_0004);
    rd_chk("R9 capture while disabled", 20'h10030, 64'h8000_0000_0000_0004);
    chk("R9 still silent", {44'h0, irq_lvl}, 64'h0);
    @(negedge clk);
    int_enable = 1'b1;
    idle(1);
    chk("R9 lines back", {44'h0, irq_lvl}, {44'h0, exp_lines(64'h8000_0000_0000_0004)});

    // R10 set/clear read zero, status write ignored
    rd_chk("R10 set slot reads zero", 20'h10020, 64'h0);
    rd_chk("R10 clear slot reads zero", 20'h10028, 64'h0);
    wr(20'h10030, 64'h0F0F_0F0F_0F0F_0F0F);
    rd_chk("R10 status write ignored", 20'h10030, 64'h8000_0000_0000_0004);

    // R11 unmapped addresses
    wr(20'h10038, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(20'h00000, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_chk("R11 unmapped reads zero", 20'h10038, 64'h0);
    rd_chk("R11 status untouched", 20'h10030, 64'h8000_0000_0000_0004);
    rd_chk("R11 mask1 untouched", 20'h10008, bm[1]);

    // Random mix against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      hw_src = ($urandom % 6 == 0) ? (64'h1 << ($urandom % 64)) : 64'h0;
      reg_wr = 1'b0; reg_rd = 1'b0;
      case ($urandom % 8)
        0: begin reg_wr = 1'b1; reg_addr = 20'h10020; reg_wdata = {$urandom, $urandom} & {$urandom, $urandom}; end
        1: begin reg_wr = 1'b1; reg_addr = 20'h10028; reg_wdata = {$urandom, $urandom}; end
        2: begin reg_wr = 1'b1; reg_addr = 20'h10000 + 20'(8 * ($urandom % 4)); reg_wdata = {$urandom, $urandom}; end
        3: begin reg_rd = 1'b1; reg_addr = 20'h10000 + 20'(8 * ($urandom % 7)); end
        4: begin reg_wr = 1'b1; reg_addr = 20'h10028; reg_wdata = hw_src | 64'(1) << ($urandom % 64); end
        5: if ($urandom % 4 == 0) int_enable = ~int_enable;
        default: ;
      endcase
    end
    @(negedge clk);
    hw_src = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    idle(3);
    report();
  end

endmodule